// File: doc/BRIEF.md
# Supply Brown-Out Sampling Controller

This block is the digital side of a supply-voltage monitor. An analog comparator reports whether the supply is under a programmable threshold. This controller brings that comparator output into the system clock domain and decides when it is evaluated. It then turns a confirmed under-voltage condition into a reset request or an interrupt request. It also drives the threshold code and the hysteresis select back to the comparator.

A single 32-bit configuration word holds all settings. Writes are blocked while a lock input is high. The fields that the start-up loader supplies (threshold, response, hysteresis, enable) take their reset values from input pins.

The comparator can be evaluated on every system clock, which is the continuous style. It can also be evaluated only on strobes from a power-of-two divider fed by a 1 kHz tick, which is the sampled style. In a standby state, detection is held off unless the configuration asks for it to stay on.

Top module: `bod_sampler_ctrl`

## Requirements
- R1: After reset the word reads as follows. Bits 21:16 hold `boot_level`, bits 4:3 hold `boot_action`, bit 2 holds `boot_hyst` and bit 1 holds `boot_enable`. The divider select (15:12), the clock-run status (9), the style (8) and stay-on-in-standby (6) read 0.
- R2: A write while `wr_lock` is high changes no field.
- R3: A write leaves the threshold field (21:16) unchanged while the stored enable bit (1) is 1. The other fields still update.
- R4: Bits 31:22, 11:10, 7, 5 and 0 always read 0, whatever is written to them.
- R5: With divider select N (bits 15:12) and the divider running (bit 9 written 1), one strobe occurs every 2^(N+1) ticks of `lp_tick`, counted from the write that started it.
- R6: In continuous style (bit 8 = 0), a change on `cmp_below` reaches `rst_req` on the third rising clock edge after it.
- R7: In sampled style (bit 8 = 1), the comparator is evaluated only on strobes. Between strobes the outputs hold the last evaluated result.
- R8: The response field (bits 4:3) decodes as follows. 1 drives `rst_req` while the under-voltage result is held. 0 and the reserved value 3 drive neither request.
- R9: With response 2, an evaluated under-voltage sets `irq_req`. The flag stays set after the supply recovers, until `irq_clr` is pulsed.
- R10: When `standby` is high and bit 6 is 0, no request is raised. When bit 6 is 1, detection continues in standby.
- R11: Bit 9 reads back the written divider-run value delayed by two `lp_tick` ticks, for both the start and the stop.
- R12: When the stored enable bit is 0, `rst_req` is 0 and `irq_req` is not set.
- R13: `level_o` and `hyst_o` always equal the stored threshold and hysteresis fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_tick | input | 1 | One-cycle pulse per 1 kHz low-power clock period |
| wr_en | input | 1 | Configuration write strobe |
| wr_lock | input | 1 | Write protection; writes are ignored while high |
| wr_data | input | 32 | Configuration write data |
| rd_data | output | 32 | Configuration readback |
| boot_level | input | 6 | Start-up threshold code |
| boot_action | input | 2 | Start-up response select |
| boot_hyst | input | 1 | Start-up hysteresis select |
| boot_enable | input | 1 | Start-up enable |
| standby | input | 1 | System is in standby |
| cmp_below | input | 1 | Asynchronous comparator output, 1 = supply under threshold |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| level_o | output | 6 | Threshold code to the comparator |
| hyst_o | output | 1 | Hysteresis select to the comparator |
| rst_req | output | 1 | Brown-out reset request (level) |
| irq_req | output | 1 | Brown-out interrupt request (sticky) |

## Verification
The hardest case to reach from the ports is the exact strobe spacing in sampled style. The divider runs on the slow tick and leaves no visible trace until the comparator result is latched. The stimulus holds `cmp_below` high and first clears any old result by disabling. It then restarts the divider with a fresh write and counts `lp_tick` pulses until `rst_req` rises. This count is compared with 2^(N+1) for several select values. The bench also drops the comparator between strobes to show that the held result persists until the next strobe.

// File: rtl/bod_pkg.sv
package bod_pkg;
  localparam int LVL_W  = 6;
  localparam int PSEL_W = 4;

  localparam int LVL_LSB  = 16;
  localparam int PSEL_LSB = 12;
  localparam int CEN_BIT  = 9;
  localparam int MODE_BIT = 8;
  localparam int RSB_BIT  = 6;
  localparam int ACT_LSB  = 3;
  localparam int HYST_BIT = 2;
  localparam int EN_BIT   = 1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_RST  = 2'd1,
    ACT_IRQ  = 2'd2,
    ACT_RSV  = 2'd3
  } act_e;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;
    logic [PSEL_W-1:0] psel;
    logic              cen;
    logic              mode;
    logic              rsb;
    act_e              act;
    logic              hyst;
    logic              en;
  } cfg_t;
endpackage

// File: rtl/bod_cfg_reg.sv
module bod_cfg_reg
  import bod_pkg::*;
#(
  parameter int CEN_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_tick,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [31:0]      wr_data,
  input  logic [LVL_W-1:0] boot_level,
  input  logic [1:0]       boot_action,
  input  logic             boot_hyst,
  input  logic             boot_enable,
  output cfg_t             cfg,
  output logic             cen_sts
);
  cfg_t                cfg_q, cfg_d;
  logic [CEN_SYNC-1:0] cen_pipe_q, cen_pipe_d;
  logic                wr_ok;
  logic                unused_wr;

  assign wr_ok     = wr_en & ~wr_lock;
  assign unused_wr = ^{wr_data[31:LVL_LSB+LVL_W], wr_data[11:10], wr_data[7],
                       wr_data[5], wr_data[0]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ok) begin
      if (!cfg_q.en) cfg_d.lvl = wr_data[LVL_LSB +: LVL_W];
      cfg_d.psel = wr_data[PSEL_LSB +: PSEL_W];
      cfg_d.cen  = wr_data[CEN_BIT];
      cfg_d.mode = wr_data[MODE_BIT];
      cfg_d.rsb  = wr_data[RSB_BIT];
      cfg_d.act  = act_e'(wr_data[ACT_LSB +: 2]);
      cfg_d.hyst = wr_data[HYST_BIT];
      cfg_d.en   = wr_data[EN_BIT];
    end
  end

  generate
    if (CEN_SYNC > 1) begin : g_pipe
      always_comb begin
        cen_pipe_d = cen_pipe_q;
        if (lp_tick) cen_pipe_d = {cen_pipe_q[CEN_SYNC-2:0], cfg_q.cen};
      end
    end else begin : g_single
      always_comb begin
        cen_pipe_d = cen_pipe_q;
        if (lp_tick) cen_pipe_d = cfg_q.cen;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.lvl  <= boot_level;
      cfg_q.psel <= '0;
      cfg_q.cen  <= 1'b0;
      cfg_q.mode <= 1'b0;
      cfg_q.rsb  <= 1'b0;
      cfg_q.act  <= act_e'(boot_action);
      cfg_q.hyst <= boot_hyst;
      cfg_q.en   <= boot_enable;
      cen_pipe_q <= '0;
    end else begin
      cfg_q      <= cfg_d;
      cen_pipe_q <= cen_pipe_d;
    end
  end

  assign cfg     = cfg_q;
  assign cen_sts = cen_pipe_q[CEN_SYNC-1];
endmodule

// File: rtl/bod_prescaler.sv
module bod_prescaler #(
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              lp_tick,
  input  logic [PSEL_W-1:0] psel,
  output logic              strobe
);
  localparam int CNT_W = 2 ** PSEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   lim_full;
  logic [CNT_W-1:0] lim;
  logic [PSEL_W:0]  shamt;
  logic             hit;
  logic             unused_lim;

  assign shamt      = {1'b0, psel} + 1'b1;
  assign lim_full   = ({{CNT_W{1'b0}}, 1'b1} << shamt) - 1'b1;
  assign lim        = lim_full[CNT_W-1:0];
  assign unused_lim = lim_full[CNT_W];
  assign hit        = run & lp_tick & (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (hit)     cnt_d = '0;
    else if (lp_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe = hit;
endmodule

// File: rtl/bod_detect.sv
module bod_detect
  import bod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async,
  input  logic active,
  input  logic strobe,
  input  logic mode,
  input  act_e act,
  input  logic irq_clr,
  output logic rst_req,
  output logic irq_req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cmp_s, eval;
  logic                   below_q, below_d;
  logic                   irq_q, irq_d;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_async};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= cmp_async;
      end
    end
  endgenerate

  assign cmp_s = sync_q[SYNC_STAGES-1];
  assign eval  = active & (~mode | strobe);

  always_comb begin
    below_d = below_q;
    if (!active)   below_d = 1'b0;
    else if (eval) below_d = cmp_s;
    irq_d = irq_q;
    if (eval && cmp_s && act == ACT_IRQ) irq_d = 1'b1;
    else if (irq_clr)                    irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      below_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      below_q <= below_d;
      irq_q   <= irq_d;
    end
  end

  assign rst_req = below_q & active & (act == ACT_RST);
  assign irq_req = irq_q;
endmodule

// File: rtl/bod_sampler_ctrl.sv
module bod_sampler_ctrl
  import bod_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CEN_SYNC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_tick,
  input  logic             wr_en,
  input  logic             wr_lock,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [LVL_W-1:0] boot_level,
  input  logic [1:0]       boot_action,
  input  logic             boot_hyst,
  input  logic             boot_enable,
  input  logic             standby,
  input  logic             cmp_below,
  input  logic             irq_clr,
  output logic [LVL_W-1:0] level_o,
  output logic             hyst_o,
  output logic             rst_req,
  output logic             irq_req
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  cfg_t       cfg;
  logic       cen_sts, strobe, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  bod_cfg_reg #(.CEN_SYNC(CEN_SYNC)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .lp_tick(lp_tick),
    .wr_en(wr_en), .wr_lock(wr_lock), .wr_data(wr_data),
    .boot_level(boot_level), .boot_action(boot_action),
    .boot_hyst(boot_hyst), .boot_enable(boot_enable),
    .cfg(cfg), .cen_sts(cen_sts)
  );

  bod_prescaler #(.PSEL_W(PSEL_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .run(cfg.cen), .lp_tick(lp_tick),
    .psel(cfg.psel), .strobe(strobe)
  );

  assign active = cfg.en & (cfg.rsb | ~standby);

  bod_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(rst_n_s), .cmp_async(cmp_below), .active(active),
    .strobe(strobe), .mode(cfg.mode), .act(cfg.act), .irq_clr(irq_clr),
    .rst_req(rst_req), .irq_req(irq_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[LVL_LSB +: LVL_W]   = cfg.lvl;
    rd_data[PSEL_LSB +: PSEL_W] = cfg.psel;
    rd_data[CEN_BIT]            = cen_sts;
    rd_data[MODE_BIT]           = cfg.mode;
    rd_data[RSB_BIT]            = cfg.rsb;
    rd_data[ACT_LSB +: 2]       = cfg.act;
    rd_data[HYST_BIT]           = cfg.hyst;
    rd_data[EN_BIT]             = cfg.en;
  end

  assign level_o = cfg.lvl;
  assign hyst_o  = cfg.hyst;
endmodule

// File: rtl/bod_sampler_ctrl_chk.sv
module bod_sampler_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_lock,
  input logic        standby,
  input logic        irq_clr,
  input logic [31:0] rd_data,
  input logic [5:0]  level_o,
  input logic        rst_req,
  input logic        irq_req
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lock) |=> $stable(rd_data & ~32'h0000_0200)); // R2

  AST_LEVEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(rd_data[1])) |-> $stable(level_o)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hFFC0_0CA1) == 32'h0); // R4

  AST_RST_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rd_data[4:3] == 2'd1)); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_clr) |=> irq_req); // R9

  AST_IRQ_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && rd_data[4:3] != 2'd2) |=> !irq_req); // R8

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !rd_data[6]) |-> !rst_req); // R10

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> !rst_req); // R12
endmodule

bind bod_sampler_ctrl bod_sampler_ctrl_chk u_chk (.*);

// File: tb/sim_bod_sampler_ctrl.sv
module sim_bod_sampler_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_tick = 1'b0, wr_en = 1'b0, wr_lock = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  boot_level = 6'h2A;
  logic [1:0]  boot_action = 2'd1;
  logic        boot_hyst = 1'b1, boot_enable = 1'b0;
  logic        standby = 1'b0, cmp_below = 1'b0, irq_clr = 1'b0;
  logic [5:0]  level_o;
  logic        hyst_o, rst_req, irq_req;

  int checks = 0, fails = 0, cyc = 0;
  logic [5:0] m_lvl; logic [3:0] m_psel; logic m_mode, m_rsb, m_hyst, m_en;
  logic [1:0] m_act;

  bod_sampler_ctrl u0 (.*);

  always #5 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000) begin
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd();
    return {10'd0, m_lvl, m_psel, 2'b00, 1'b0, m_mode, 1'b0, m_rsb, 1'b0,
            m_act, m_hyst, m_en, 1'b0};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d, input logic lk);
    wr_data = d; wr_lock = lk; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_lock = 1'b0;
    if (!lk) begin
      if (!m_en) m_lvl = d[21:16];
      m_psel = d[15:12]; m_mode = d[8]; m_rsb = d[6];
      m_act = d[4:3]; m_hyst = d[2]; m_en = d[1];
    end
  endtask

  task automatic tick();
    lp_tick = 1'b1;
    @(negedge clk);
    lp_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic measure(input int n);
    int cnt;
    wr(32'h0, 1'b0);
    cmp_below = 1'b1;
    step(4);
    wr((n << 12) | 32'h0000_030A, 1'b0);
    cnt = 0;
    while (!rst_req && cnt < 70000) begin
      tick();
      cnt++;
    end
    chk("R5 strobe spacing", cnt, 32'd1 << (n + 1));
    cmp_below = 1'b0;
    step(5);
    chk("R7 result held between strobes", {31'd0, rst_req}, 32'd1);
    cnt = 0;
    while (rst_req && cnt < 70000) begin
      tick();
      cnt++;
    end
    chk("R7 next strobe takes new result", cnt, 32'd1 << (n + 1));
    cmp_below = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    logic [31:0] d;
    logic lk;
    m_lvl = 6'h2A; m_psel = '0; m_mode = 0; m_rsb = 0; m_act = 2'd1;
    m_hyst = 1; m_en = 0;
    seed = $urandom(32'd20240611);
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset readback
    chk("R1 reset word", rd_data, 32'h002A_000C);
    chk("R13 level out", {26'd0, level_o}, 32'h2A);

    // R4 reserved bits
    wr(32'hFFFF_FDFF, 1'b0);
    step(1);
    chk("R4 reserved read zero", rd_data, 32'h003F_F15E);
    // R3 level frozen while enabled
    wr(32'h0015_0002, 1'b0);
    step(1);
    chk("R3 level ignored while enabled", rd_data, model_rd());
    chk("R3 level output", {26'd0, level_o}, 32'h3F);
    // R2 lock
    wr(32'h0000_0000, 1'b1);
    step(1);
    chk("R2 locked write ignored", rd_data, 32'h003F_0002);
    wr(32'h0000_0000, 1'b0);
    wr(32'h0011_0000, 1'b0);
    step(1);
    chk("R3 level written while disabled", {26'd0, level_o}, 32'h11);

    // R11 clock-run readback lag
    tick(); tick();
    wr(32'h0000_0200, 1'b0);
    step(1);
    chk("R11 start not yet visible", {31'd0, rd_data[9]}, 0);
    tick();
    chk("R11 start after one tick", {31'd0, rd_data[9]}, 0);
    tick();
    chk("R11 start after two ticks", {31'd0, rd_data[9]}, 1);
    wr(32'h0000_0000, 1'b0);
    step(1);
    chk("R11 stop not yet visible", {31'd0, rd_data[9]}, 1);
    tick();
    chk("R11 stop after one tick", {31'd0, rd_data[9]}, 1);
    tick();
    chk("R11 stop after two ticks", {31'd0, rd_data[9]}, 0);

    // R6 continuous latency and R8 reset action
    wr(32'h0000_000A, 1'b0);
    step(2);
    cmp_below = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R6 not after two edges", {31'd0, rst_req}, 0);
    @(posedge clk); #1;
    chk("R6 visible after three edges", {31'd0, rst_req}, 1);
    step(2);
    chk("R8 reset request level", {31'd0, rst_req}, 1);
    // R12 enable gating
    wr(32'h0000_0008, 1'b0);
    step(4);
    chk("R12 disabled no reset", {31'd0, rst_req}, 0);
    // R8 none and reserved
    wr(32'h0000_0002, 1'b0);
    step(4);
    chk("R8 none action", {30'd0, rst_req, irq_req}, 0);
    wr(32'h0000_001A, 1'b0);
    step(4);
    chk("R8 reserved action", {30'd0, rst_req, irq_req}, 0);
    // R10 standby
    standby = 1'b1;
    wr(32'h0000_000A, 1'b0);
    step(4);
    chk("R10 standby suppresses", {31'd0, rst_req}, 0);
    wr(32'h0000_004A, 1'b0);
    step(4);
    chk("R10 stay-on in standby", {31'd0, rst_req}, 1);
    standby = 1'b0;
    // R9 sticky interrupt
    wr(32'h0000_0012, 1'b0);
    step(4);
    chk("R9 interrupt set", {30'd0, rst_req, irq_req}, 1);
    cmp_below = 1'b0;
    step(5);
    chk("R9 interrupt sticky", {31'd0, irq_req}, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    step(1);
    chk("R9 interrupt cleared", {31'd0, irq_req}, 0);
    cmp_below = 1'b0;
    wr(32'h0, 1'b0);
    step(4);

    // R5 / R7 sampled style for several divider selects
    measure(0);
    measure(2);
    measure(5);
    wr(32'h0, 1'b0);
    step(4);

    // random configuration traffic, R2 R3 R4 R13
    for (int i = 0; i < 60; i++) begin
      d  = $urandom;
      lk = ($urandom % 4) == 0;
      wr(d, lk);
      step(1);
      chk("R2/R3 random readback", rd_data & ~32'h0000_0200, model_rd());
      chk("R13 outputs track fields", {25'd0, level_o, hyst_o}, {25'd0, m_lvl, m_hyst});
    end

    summary();
    $finish;
  end
endmodule